// File: doc/BRIEF.md
# Transactional Cache-Line Conflict Tracker

This block follows the speculative memory traffic of one core while it runs a hardware transaction. A small, fully associative table keeps one entry for each 64-byte line the transaction has touched. Each entry holds the line tag, a read flag, a write flag, a per-word modified mask and a private copy of every stored word. Stores go into the table and do not reach memory. Loads that hit a word the transaction has already written return the private copy, and all other loads return the word that memory supplies.

Remote agents present snoop addresses. The block compares them against the table and aborts the transaction on any coherence conflict. It also aborts when a new line finds the table full, when an access is marked uncached, or when the external interrupt input is raised. An abort throws away every private copy and every flag, so memory never sees any part of the transaction. When the core ends the transaction without an abort, the block drains each modified word in order through a valid/ready write port. It ignores snoops until the drain is finished, so the write set becomes visible as one unit.

Top module: `tct_tracker`

## Requirements
- R1: After reset the block is idle: `txActive`, `busy`, `aborted` and `wrValid` are all low.
- R2: During a transaction, a load returns the buffered word when its line holds a store to that same word. Otherwise it returns `memWord` unchanged. A store never drives `wrValid` before commit.
- R3: A snoop write that hits a line the transaction has read aborts it with cause code 0 (conflict). A snoop read of a line that has only been read does not abort.
- R4: A snoop read or snoop write that hits a line the transaction has written aborts it with cause code 0 (conflict).
- R5: The table holds `ENTRIES` lines (default 4). An access to a line not in the table while all entries are in use aborts the transaction with cause code 1 (capacity). An access to a line already in the table still succeeds when the table is full.
- R6: A load or store flagged uncached inside a transaction aborts it with cause code 2 (uncached).
- R7: Raising `asyncAbort` during a transaction aborts it with cause code 3 (asynchronous). This has priority over every other cause in the same cycle.
- R8: An abort discards all buffered words and flags. A later transaction that commits without stores drains nothing, and its loads return `memWord`.
- R9: Commit writes out every modified word exactly once. Lines go in allocation order and words in ascending order within a line. `wrAddr` is the line address plus word index times 4, and `wrData` is the last stored value. `busy` stays high until the last word is accepted. While `wrReady` is low, `wrValid`, `wrAddr` and `wrData` hold.
- R10: Snoops that arrive while a commit is draining cause no abort, and the drain completes intact.
- R11: `aborted` and `abortCause` stay set until the next `txBegin`, which clears `aborted`.
- R12: If an abort condition and `txEnd` fall in the same cycle, the abort wins. No drain starts and no word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txBegin | input | 1 | Start a transaction (taken while idle) |
| txEnd | input | 1 | Request commit of the active transaction |
| asyncAbort | input | 1 | Interrupt-style abort request |
| ldValid | input | 1 | Local load request |
| ldAddr | input | ADDR_W | Load byte address |
| ldUncached | input | 1 | Load targets uncached space |
| memWord | input | WORD_W | Word read from memory for the current load |
| ldData | output | WORD_W | Load result |
| stValid | input | 1 | Local store request |
| stAddr | input | ADDR_W | Store byte address |
| stData | input | WORD_W | Store data |
| stUncached | input | 1 | Store targets uncached space |
| snpValid | input | 1 | Remote snoop valid |
| snpWrite | input | 1 | Snoop is a write (else a read) |
| snpAddr | input | ADDR_W | Snoop byte address |
| wrValid | output | 1 | Commit write valid |
| wrReady | input | 1 | Memory accepts commit write |
| wrAddr | output | ADDR_W | Commit write byte address |
| wrData | output | WORD_W | Commit write data |
| busy | output | 1 | Commit drain in progress |
| txActive | output | 1 | Transaction running |
| aborted | output | 1 | Sticky abort flag |
| abortCause | output | 2 | Cause of the last abort |

## Verification
The two functions that can coincide are the abort decision and the commit request. A conflicting snoop can arrive in the same cycle as `txEnd`, or while the drain that `txEnd` starts is already under way. The bench drives a snoop read to a written line in the very cycle it raises `txEnd` and expects a conflict abort with no write at all. It also snoops the written line while the drain is stalled on `wrReady` and expects no abort and an unchanged, complete drain.

// File: rtl/tct_pkg.sv
package tct_pkg;

  typedef enum logic [1:0] {
    CAUSE_CONFLICT = 2'd0,
    CAUSE_CAPACITY = 2'd1,
    CAUSE_UNCACHED = 2'd2,
    CAUSE_ASYNC    = 2'd3
  } abortCause_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DRAIN  = 2'd2
  } txState_e;

  // strobes from control to the line table
  typedef struct packed {
    logic clearAll;
    logic update;
    logic isStore;
    logic alloc;
  } tblStrobe_t;

endpackage

// File: rtl/tct_datapath.sv
module tct_datapath
  import tct_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int BOFF_W = $clog2(WORD_W / 8),
  localparam int WORDS  = LINE_BYTES / (WORD_W / 8),
  localparam int WIDX_W = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tblStrobe_t        strobe,
  input  logic [IDX_W-1:0]  slotIdx,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [WORD_W-1:0] stData,
  input  logic [WORD_W-1:0] memWord,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [IDX_W-1:0]  drainEnt,
  input  logic [WIDX_W-1:0] drainWord,
  output logic              accHit,
  output logic [IDX_W-1:0]  accHitIdx,
  output logic              freeAvail,
  output logic [IDX_W-1:0]  freeIdx,
  output logic              snpConflict,
  output logic [WORD_W-1:0] ldData,
  output logic              drainHas,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData
);

  logic [ENTRIES-1:0]            validQ, rdQ, wrQ;
  logic [ENTRIES-1:0][TAG_W-1:0] tagQ;
  logic [ENTRIES-1:0][WORDS-1:0] maskQ;
  logic [WORD_W-1:0]             dataQ [ENTRIES][WORDS];

  logic [TAG_W-1:0]  accTag, snpTag;
  logic [WIDX_W-1:0] accWord;

  assign accTag  = accAddr[ADDR_W-1:OFF_W];
  assign accWord = accAddr[OFF_W-1:BOFF_W];
  assign snpTag  = snpAddr[ADDR_W-1:OFF_W];

  // lookup of local access, snoop and free slot
  always_comb begin
    accHit      = 1'b0;
    accHitIdx   = '0;
    freeAvail   = 1'b0;
    freeIdx     = '0;
    snpConflict = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        freeAvail = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (validQ[i] && tagQ[i] == accTag) begin
        accHit    = 1'b1;
        accHitIdx = IDX_W'(i);
      end
      if (snpValid && validQ[i] && tagQ[i] == snpTag &&
          (wrQ[i] || (snpWrite && rdQ[i])))
        snpConflict = 1'b1;
    end
  end

  assign ldData = (accHit && maskQ[accHitIdx][accWord]) ?
                  dataQ[accHitIdx][accWord] : memWord;

  assign drainHas = validQ[drainEnt] && maskQ[drainEnt][drainWord];
  assign wrAddr   = {tagQ[drainEnt], drainWord, BOFF_W'(0)};
  assign wrData   = dataQ[drainEnt][drainWord];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      rdQ    <= '0;
      wrQ    <= '0;
      maskQ  <= '0;
      tagQ   <= '0;
    end else if (strobe.clearAll) begin
      validQ <= '0;
      rdQ    <= '0;
      wrQ    <= '0;
      maskQ  <= '0;
    end else if (strobe.update) begin
      if (strobe.alloc) begin
        validQ[slotIdx] <= 1'b1;
        tagQ[slotIdx]   <= accTag;
      end
      if (strobe.isStore) begin
        wrQ[slotIdx]            <= 1'b1;
        maskQ[slotIdx][accWord] <= 1'b1;
      end else begin
        rdQ[slotIdx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.update && strobe.isStore && !strobe.clearAll)
      dataQ[slotIdx][accWord] <= stData;
  end

  // R5: a new slot is only claimed on a miss with a free entry
  p_alloc_free_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.update && strobe.alloc) |-> (freeAvail && !accHit));

  // R8: after a clear no line is tracked
  p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (validQ == '0 && maskQ == '0));

endmodule

// File: rtl/tct_control.sv
module tct_control
  import tct_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int WORDS   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBegin,
  input  logic              txEnd,
  input  logic              asyncAbort,
  input  logic              ldValid,
  input  logic              stValid,
  input  logic              accUncached,
  input  logic              accHit,
  input  logic [IDX_W-1:0]  accHitIdx,
  input  logic              freeAvail,
  input  logic [IDX_W-1:0]  freeIdx,
  input  logic              snpConflict,
  input  logic              drainHas,
  input  logic              wrReady,
  output tblStrobe_t        strobe,
  output logic [IDX_W-1:0]  slotIdx,
  output logic [IDX_W-1:0]  drainEnt,
  output logic [WIDX_W-1:0] drainWord,
  output logic              wrValid,
  output logic              busy,
  output logic              txActive,
  output logic              aborted,
  output logic [1:0]        abortCause
);

  txState_e    stateQ;
  logic        abortedQ;
  abortCause_e causeQ, causeNext;
  logic        abortNow, accReq, step, lastPos, drainDone;

  assign accReq = ldValid || stValid;

  always_comb begin
    abortNow  = 1'b0;
    causeNext = causeQ;
    if (stateQ == ST_ACTIVE) begin
      if (asyncAbort) begin
        abortNow  = 1'b1;
        causeNext = CAUSE_ASYNC;
      end else if (snpConflict) begin
        abortNow  = 1'b1;
        causeNext = CAUSE_CONFLICT;
      end else if (accReq && accUncached) begin
        abortNow  = 1'b1;
        causeNext = CAUSE_UNCACHED;
      end else if (accReq && !accHit && !freeAvail) begin
        abortNow  = 1'b1;
        causeNext = CAUSE_CAPACITY;
      end
    end
  end

  assign wrValid   = (stateQ == ST_DRAIN) && drainHas;
  assign step      = (stateQ == ST_DRAIN) && (!drainHas || wrReady);
  assign lastPos   = (drainEnt == IDX_W'(ENTRIES - 1)) &&
                     (drainWord == WIDX_W'(WORDS - 1));
  assign drainDone = step && lastPos;

  always_comb begin
    strobe.clearAll = abortNow || drainDone || (stateQ == ST_IDLE && txBegin);
    strobe.update   = (stateQ == ST_ACTIVE) && accReq && !abortNow;
    strobe.isStore  = stValid;
    strobe.alloc    = !accHit;
    slotIdx         = accHit ? accHitIdx : freeIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      abortedQ  <= 1'b0;
      causeQ    <= CAUSE_CONFLICT;
      drainEnt  <= '0;
      drainWord <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (txBegin) begin
          stateQ   <= ST_ACTIVE;
          abortedQ <= 1'b0;
        end
        ST_ACTIVE: if (abortNow) begin
          stateQ   <= ST_IDLE;
          abortedQ <= 1'b1;
          causeQ   <= causeNext;
        end else if (txEnd) begin
          stateQ    <= ST_DRAIN;
          drainEnt  <= '0;
          drainWord <= '0;
        end
        ST_DRAIN: if (step) begin
          if (lastPos) begin
            stateQ <= ST_IDLE;
          end else if (drainWord == WIDX_W'(WORDS - 1)) begin
            drainWord <= '0;
            drainEnt  <= drainEnt + 1'b1;
          end else begin
            drainWord <= drainWord + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (stateQ == ST_DRAIN);
  assign txActive   = (stateQ == ST_ACTIVE);
  assign aborted    = abortedQ;
  assign abortCause = causeQ;

  // R11: the abort flag holds until a new transaction begins
  p_sticky_abort_r11: assert property (@(posedge clk) disable iff (!rstN)
    (aborted && !txBegin) |=> aborted);

  // R10: a drain never ends in an abort
  p_drain_no_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !aborted);

  // R12: an abort leaves neither transaction nor drain running
  p_abort_stops_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aborted) |-> (!txActive && !busy));

endmodule

// File: rtl/tct_tracker.sv
module tct_tracker
  import tct_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBegin,
  input  logic              txEnd,
  input  logic              asyncAbort,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              ldUncached,
  input  logic [WORD_W-1:0] memWord,
  output logic [WORD_W-1:0] ldData,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [WORD_W-1:0] stData,
  input  logic              stUncached,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic              busy,
  output logic              txActive,
  output logic              aborted,
  output logic [1:0]        abortCause
);

  localparam int WORDS  = LINE_BYTES / (WORD_W / 8);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int WIDX_W = $clog2(WORDS);

  tblStrobe_t        strobe;
  logic [IDX_W-1:0]  slotIdx, accHitIdx, freeIdx, drainEnt;
  logic [WIDX_W-1:0] drainWord;
  logic              accHit, freeAvail, snpConflict, drainHas, accUncached;
  logic [ADDR_W-1:0] accAddr;

  assign accAddr     = stValid ? stAddr : ldAddr;
  assign accUncached = (stValid && stUncached) || (ldValid && ldUncached);

  tct_datapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES), .ENTRIES(ENTRIES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx),
    .accAddr(accAddr), .stData(stData), .memWord(memWord),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpAddr(snpAddr),
    .drainEnt(drainEnt), .drainWord(drainWord),
    .accHit(accHit), .accHitIdx(accHitIdx), .freeAvail(freeAvail),
    .freeIdx(freeIdx), .snpConflict(snpConflict), .ldData(ldData),
    .drainHas(drainHas), .wrAddr(wrAddr), .wrData(wrData)
  );

  tct_control #(
    .ENTRIES(ENTRIES), .WORDS(WORDS)
  ) u_control (
    .clk(clk), .rstN(rstN), .txBegin(txBegin), .txEnd(txEnd),
    .asyncAbort(asyncAbort), .ldValid(ldValid), .stValid(stValid),
    .accUncached(accUncached), .accHit(accHit), .accHitIdx(accHitIdx),
    .freeAvail(freeAvail), .freeIdx(freeIdx), .snpConflict(snpConflict),
    .drainHas(drainHas), .wrReady(wrReady), .strobe(strobe),
    .slotIdx(slotIdx), .drainEnt(drainEnt), .drainWord(drainWord),
    .wrValid(wrValid), .busy(busy), .txActive(txActive),
    .aborted(aborted), .abortCause(abortCause)
  );

  // R9: a stalled commit write holds its address and data
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData)));

  // R2: nothing leaves the block while a transaction is running
  p_no_early_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    txActive |-> !wrValid);

endmodule

// File: tb/tct_tracker_bench.sv
module tct_tracker_bench;

  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int NENT   = 4;
  localparam int NWORD  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txBegin = 0, txEnd = 0, asyncAbort = 0;
  logic ldValid = 0, ldUncached = 0, stValid = 0, stUncached = 0;
  logic [ADDR_W-1:0] ldAddr = '0, stAddr = '0, snpAddr = '0;
  logic [WORD_W-1:0] memWord = '0, stData = '0;
  logic snpValid = 0, snpWrite = 0, wrReady = 0;
  logic [WORD_W-1:0] ldData, wrData;
  logic [ADDR_W-1:0] wrAddr;
  logic wrValid, busy, txActive, aborted;
  logic [1:0] abortCause;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the transaction
  logic [25:0] mTag [NENT];
  logic [NWORD-1:0] mMask [NENT];
  logic [WORD_W-1:0] mData [NENT][NWORD];
  int mCount;

  tct_tracker u_tct_tracker (
    .clk(clk), .rstN(rstN), .txBegin(txBegin), .txEnd(txEnd),
    .asyncAbort(asyncAbort), .ldValid(ldValid), .ldAddr(ldAddr),
    .ldUncached(ldUncached), .memWord(memWord), .ldData(ldData),
    .stValid(stValid), .stAddr(stAddr), .stData(stData),
    .stUncached(stUncached), .snpValid(snpValid), .snpWrite(snpWrite),
    .snpAddr(snpAddr), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData), .busy(busy), .txActive(txActive),
    .aborted(aborted), .abortCause(abortCause)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int findLine(input logic [31:0] a);
    for (int i = 0; i < mCount; i++)
      if (mTag[i] == a[31:6]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] expLoad(input logic [31:0] a,
                                          input logic [31:0] mem);
    int e;
    e = findLine(a);
    if (e >= 0 && mMask[e][a[5:2]]) return mData[e][a[5:2]];
    return mem;
  endfunction

  task automatic modelClear();
    mCount = 0;
    for (int i = 0; i < NENT; i++) mMask[i] = '0;
  endtask

  task automatic modelTouch(input logic [31:0] a, input bit isSt,
                            input logic [31:0] d);
    int e;
    e = findLine(a);
    if (e < 0 && mCount < NENT) begin
      e = mCount;
      mTag[e] = a[31:6];
      mCount++;
    end
    if (isSt && e >= 0) begin
      mMask[e][a[5:2]] = 1'b1;
      mData[e][a[5:2]] = d;
    end
  endtask

  task automatic doBegin();
    @(negedge clk) txBegin = 1;
    @(negedge clk) txBegin = 0;
    modelClear();
  endtask

  task automatic doStore(input logic [31:0] a, input logic [31:0] d,
                         input bit unc);
    @(negedge clk);
    stValid = 1; stAddr = a; stData = d; stUncached = unc;
    #1 chk(!wrValid, "R2 no write before commit", 32'(wrValid), 0);
    @(negedge clk) stValid = 0; stUncached = 0;
    if (!unc) modelTouch(a, 1'b1, d);
  endtask

  task automatic doLoad(input logic [31:0] a, input logic [31:0] mem,
                        input bit unc, input string req);
    logic [31:0] e;
    e = expLoad(a, mem);
    @(negedge clk);
    ldValid = 1; ldAddr = a; memWord = mem; ldUncached = unc;
    #1 if (!unc) chk(ldData == e, req, ldData, e);
    @(negedge clk) ldValid = 0; ldUncached = 0;
    if (!unc) modelTouch(a, 1'b0, 0);
  endtask

  task automatic doSnoop(input logic [31:0] a, input bit wr);
    @(negedge clk) snpValid = 1; snpWrite = wr; snpAddr = a;
    @(negedge clk) snpValid = 0;
  endtask

  task automatic chkAbort(input bit expAb, input logic [1:0] cause,
                          input string req);
    chk(aborted == expAb, req, 32'(aborted), 32'(expAb));
    if (expAb) begin
      chk(abortCause == cause, req, 32'(abortCause), 32'(cause));
      chk(!txActive, req, 32'(txActive), 0);
    end
  endtask

  // commit and compare the drained words against the model
  task automatic commitCollect(input logic [31:0] snoopLine, input string req);
    logic [31:0] eA [NENT*NWORD];
    logic [31:0] eD [NENT*NWORD];
    int n = 0;
    int got = 0;
    int guard = 0;
    for (int e = 0; e < mCount; e++)
      for (int w = 0; w < NWORD; w++)
        if (mMask[e][w]) begin
          eA[n] = {mTag[e], 4'(w), 2'b00};
          eD[n] = mData[e][w];
          n++;
        end
    @(negedge clk) txEnd = 1;
    @(negedge clk) txEnd = 0;
    while (busy && guard < 2000) begin
      wrReady = 1'($urandom);
      snpValid = 1'($urandom); snpWrite = 1; snpAddr = snoopLine;
      #1;
      if (wrValid && wrReady) begin
        if (got < n) begin
          chk(wrAddr == eA[got], req, wrAddr, eA[got]);
          chk(wrData == eD[got], req, wrData, eD[got]);
        end
        got++;
      end
      @(negedge clk);
      guard++;
    end
    snpValid = 0; wrReady = 0;
    chk(got == n, {req, " count"}, got, n);
    chk(!busy, {req, " busy low"}, 32'(busy), 0);
    chk(!aborted, "R10 no abort during drain", 32'(aborted), 0);
    modelClear();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] LA = 32'h1000_0000;
  localparam logic [31:0] LB = 32'h1000_0040;

  initial begin
    void'($urandom(32'd2024));
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!txActive && !busy && !aborted && !wrValid, "R1 reset idle",
        {txActive, busy, aborted, wrValid}, 0);

    // R2 forwarding and R9 single-word drain
    doBegin();
    doStore(LA + 8, 32'hCAFE_0001, 0);
    doLoad(LA + 8, 32'h1111_1111, 0, "R2 buffered word");
    doLoad(LA + 12, 32'h2222_2222, 0, "R2 unwritten word from memory");
    doLoad(LB, 32'h3333_3333, 0, "R2 read-only line from memory");
    commitCollect(LB, "R9 drain");

    // R3 read set conflicts
    doBegin();
    doLoad(LA, 32'h5, 0, "R2 load");
    doSnoop(LA, 0);
    chkAbort(0, 0, "R3 snoop read of read line");
    doSnoop(LA, 1);
    chkAbort(1, 2'd0, "R3 snoop write of read line");

    // R4 write set conflict on snoop read
    doBegin();
    doStore(LA + 4, 32'hDEAD_0004, 0);
    doSnoop(LA, 0);
    chkAbort(1, 2'd0, "R4 snoop read of written line");
    // R11 sticky
    repeat (3) @(negedge clk);
    chk(aborted && abortCause == 2'd0, "R11 sticky abort", 32'(aborted), 1);

    // R8 discarded stores
    doBegin();
    chk(!aborted, "R11 begin clears abort", 32'(aborted), 0);
    doLoad(LA + 4, 32'h7777_7777, 0, "R8 load after abort gives memory");
    commitCollect(LB, "R8 empty drain");

    // R5 capacity
    doBegin();
    for (int i = 0; i < NENT; i++) doLoad(LA + 32'(i * 64), 32'h0, 0, "R5 fill");
    doStore(LA + 32'(64 + 4), 32'h4444, 0);
    chkAbort(0, 0, "R5 hit while full");
    doLoad(LA + 32'(NENT * 64), 32'h0, 0, "R5 fill");
    chkAbort(1, 2'd1, "R5 capacity abort");

    // R6 uncached
    doBegin();
    doStore(LA, 32'h1, 1);
    chkAbort(1, 2'd2, "R6 uncached store");
    doBegin();
    doLoad(LA, 32'h1, 1, "R6");
    chkAbort(1, 2'd2, "R6 uncached load");

    // R7 asynchronous, beating a same-cycle snoop conflict
    doBegin();
    doStore(LA, 32'h9, 0);
    @(negedge clk) asyncAbort = 1; snpValid = 1; snpWrite = 1; snpAddr = LA;
    @(negedge clk) asyncAbort = 0; snpValid = 0;
    chkAbort(1, 2'd3, "R7 async abort");

    // R12 abort and commit in the same cycle
    doBegin();
    doStore(LB + 8, 32'hAB, 0);
    @(negedge clk) txEnd = 1; snpValid = 1; snpWrite = 0; snpAddr = LB;
    #1 chk(!wrValid, "R12 no write", 32'(wrValid), 0);
    @(negedge clk) txEnd = 0; snpValid = 0;
    chkAbort(1, 2'd0, "R12 abort wins over commit");
    chk(!busy && !wrValid, "R12 no drain", {busy, wrValid}, 0);
    modelClear();

    // R10 snoop during stalled drain
    doBegin();
    doStore(LA + 0, 32'hA0, 0);
    doStore(LA + 20, 32'hA5, 0);
    doStore(LB + 60, 32'hBF, 0);
    @(negedge clk) txEnd = 1;
    @(negedge clk) txEnd = 0; wrReady = 0;
    for (int i = 0; i < 3; i++) begin
      snpValid = 1; snpWrite = 1; snpAddr = LA;
      @(negedge clk);
      chk(wrValid && wrAddr == LA && wrData == 32'hA0, "R9 stall holds",
          wrAddr, LA);
      chk(!aborted && busy, "R10 snoop in drain", 32'(aborted), 0);
    end
    snpValid = 0;
    // finish the drain; the first word is still pending
    begin
      logic [31:0] ea [3];
      logic [31:0] ed [3];
      int got = 0;
      ea[0] = LA; ed[0] = 32'hA0;
      ea[1] = LA + 20; ed[1] = 32'hA5;
      ea[2] = LB + 60; ed[2] = 32'hBF;
      while (busy && got < 10) begin
        wrReady = 1; #1;
        if (wrValid) begin
          if (got < 3) chk(wrAddr == ea[got] && wrData == ed[got],
                           "R9 ordered drain", wrAddr, ea[got]);
          got++;
        end
        @(negedge clk);
      end
      wrReady = 0;
      chk(got == 3, "R9 stalled drain count", got, 3);
    end
    modelClear();

    // random transactions, within capacity
    for (int t = 0; t < 40; t++) begin
      doBegin();
      for (int k = 0; k < 12; k++) begin
        logic [31:0] a;
        a = LA + 32'(($urandom % 3) * 64) + 32'(($urandom % NWORD) * 4);
        if ($urandom % 2) doStore(a, $urandom, 0);
        else doLoad(a, $urandom, 0, "R2 random load");
      end
      chkAbort(0, 0, "R3 random no abort");
      commitCollect(LA + 32'(3 * 64), "R9 random drain");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule